// File: doc/BRIEF.md
# Machine-Check and Checkstop Controller

This block gathers error strobes from a processor's bus interface, its caches and tags, and two external pins, and decides for each cycle whether the errors seen raise a recoverable machine-check interrupt or drive the core into a permanent halt. The machine-check-enable bit of the machine state selects the path. Set, a qualified error raises an interrupt request that stays pending until it is acknowledged. Clear, the same error halts the core and asserts the checkstop output pin. Only a hard reset leaves the halted state.

A small software-writable control register masks the machine-check pin and turns the bus address-parity and data-parity checks on or off. With those checks off, the core can run with memory that supplies no parity. Two further enable pins, driven from the L2 control register, gate the locked-line snoop-hit error and the L2 tag parity error. A one-hot source latch records which source caused the halt. Software or a debug port reads it after the event.

All control and status pins are plain level signals. Error strobes are sampled on each rising clock edge, and the block applies no back-pressure.

Top module: `mc_checkstop_ctrl`

## Requirements
- R1: `ckstp_out` and `core_halt` go high one cycle after the checkstop state is entered. They stay high, whatever the inputs do, until `rst_n` is driven low.
- R2: A qualified machine-check event with `msr_me`=0 enters checkstop. With `msr_me`=1 the same event sets `mc_irq` in the next cycle instead and does not enter checkstop.
- R3: `ckstp_in` high enters checkstop in the next cycle whatever `msr_me` is. In a cycle where `ckstp_in` and a qualified event are both present, checkstop wins and `mc_irq` is not raised.
- R4: Control bit 0 enables the machine-check pin `mcp_in`. While the bit is 0, `mcp_in` causes neither an interrupt nor a checkstop.
- R5: Control bit 2 enables address-parity errors (`bus_apar_err`) and control bit 3 enables data-parity errors (`bus_dpar_err`). A parity error whose bit is 0 is ignored.
- R6: `snoop_lock_hit` qualifies only while `l2_snoop_err_en`=1. `par_err[4]` (L2 tag) qualifies only while `l2_tag_par_en`=1.
- R7: `bus_tea` and `par_err[3:0]` always qualify. `par_err` bit order is: 0 instruction tag, 1 data tag, 2 instruction cache, 3 data cache, 4 L2 tag.
- R8: `src_latch` is zero after reset and one-hot once checkstop is entered. Its bit map is: 0 transfer error, 1 address parity, 2 data parity, 3 machine-check pin, 4 locked snoop hit, 5 to 9 `par_err[0]` to `par_err[4]`, 10 checkstop pin. If several sources arrive in the entry cycle, the checkstop pin wins, then the lowest index. `src_latch` is loaded only in the entry cycle and is frozen afterwards.
- R9: `mc_irq` stays high until `mc_ack` is pulsed. Events that arrive while it is pending merge into the same request. A raising event in the same cycle as `mc_ack` keeps `mc_irq` high.
- R10: Once in checkstop, events raise no new `mc_irq`. A pending request still clears on `mc_ack`.
- R11: `ctl_rd_data` resets to zero. A write loads bits 0, 2 and 3 only. All other bits read as zero whatever is written. A new control value takes effect in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, active low |
| bus_tea | input | 1 | Bus transfer-error strobe |
| bus_apar_err | input | 1 | Bus address-parity error strobe |
| bus_dpar_err | input | 1 | Bus data-parity error strobe |
| mcp_in | input | 1 | Machine-check input pin |
| ckstp_in | input | 1 | Checkstop input pin |
| snoop_lock_hit | input | 1 | Snoop hit on a locked L2 line |
| par_err | input | 5 | Tag and cache parity-error strobes |
| l2_snoop_err_en | input | 1 | L2 control: locked snoop-hit error enable |
| l2_tag_par_en | input | 1 | L2 control: L2 tag parity enable |
| msr_me | input | 1 | Machine-check-enable bit of the machine state |
| ctl_wr_en | input | 1 | Control register write strobe |
| ctl_wr_data | input | 8 | Control register write data |
| ctl_rd_data | output | 8 | Control register read value |
| mc_ack | input | 1 | Interrupt acknowledge pulse |
| mc_irq | output | 1 | Machine-check interrupt request |
| core_halt | output | 1 | Halt to the core |
| ckstp_out | output | 1 | Checkstop output pin |
| src_latch | output | 11 | One-hot checkstop source capture |

## Verification
Every result is one register stage behind its cause. Strobes sampled at edge N show on `ckstp_out`, `core_halt`, `src_latch` and `mc_irq` after edge N. A control write at edge N appears on `ctl_rd_data` after edge N and gates events only from edge N+1. The bench drives inputs on the falling edge, steps a behavioural model on the rising edge, and compares all outputs with it on the next falling edge. Directed checks sample exactly one falling edge after the stimulus, so each looks at the first cycle in which the result is due.

// File: rtl/mc_pkg.sv
package mc_pkg;
  // control register geometry
  localparam int CTL_W       = 8;
  localparam int CTL_PIN_EN  = 0;
  localparam int CTL_APAR_EN = 2;
  localparam int CTL_DPAR_EN = 3;
  localparam logic [CTL_W-1:0] CTL_MASK =
    CTL_W'((1 << CTL_PIN_EN) | (1 << CTL_APAR_EN) | (1 << CTL_DPAR_EN));

  // cache/tag parity strobe positions
  localparam int PAR_N     = 5;
  localparam int PAR_L2TAG = 4;

  // source latch bit map; index order is also capture priority
  localparam int S_TEA   = 0;
  localparam int S_APAR  = 1;
  localparam int S_DPAR  = 2;
  localparam int S_MCP   = 3;
  localparam int S_SNOOP = 4;
  localparam int S_PAR0  = 5;
  localparam int MC_N    = S_PAR0 + PAR_N;   // machine-check sources
  localparam int S_CKIN  = MC_N;             // checkstop pin
  localparam int NSRC    = MC_N + 1;
endpackage

// File: rtl/mc_ctl_reg.sv
module mc_ctl_reg #(
  parameter int W = 8,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] q
);
  logic [W-1:0] r;

  // only implemented bits hold state; others stay zero
  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      if (MASK[i]) begin : g_impl
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)     r[i] <= 1'b0;
          else if (wr_en) r[i] <= wr_data[i];
        end
      end else begin : g_zero
        assign r[i] = 1'b0;
      end
    end
  endgenerate

  assign q = r;
endmodule

// File: rtl/mc_qualify.sv
module mc_qualify
  import mc_pkg::*;
(
  input  logic             bus_tea,
  input  logic             bus_apar_err,
  input  logic             bus_dpar_err,
  input  logic             mcp_in,
  input  logic             snoop_lock_hit,
  input  logic [PAR_N-1:0] par_err,
  input  logic             l2_snoop_err_en,
  input  logic             l2_tag_par_en,
  input  logic [CTL_W-1:0] ctl,
  output logic [MC_N-1:0]  qual
);
  always_comb begin
    qual          = '0;
    qual[S_TEA]   = bus_tea;
    qual[S_APAR]  = bus_apar_err & ctl[CTL_APAR_EN];
    qual[S_DPAR]  = bus_dpar_err & ctl[CTL_DPAR_EN];
    qual[S_MCP]   = mcp_in & ctl[CTL_PIN_EN];
    qual[S_SNOOP] = snoop_lock_hit & l2_snoop_err_en;
    for (int i = 0; i < PAR_N; i++) begin
      if (i == PAR_L2TAG) qual[S_PAR0+i] = par_err[i] & l2_tag_par_en;
      else                qual[S_PAR0+i] = par_err[i];
    end
  end
endmodule

// File: rtl/mc_first_pick.sv
module mc_first_pick #(
  parameter int N = 8
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  generate
    for (genvar i = 0; i < N; i++) begin : g_pick
      assign seen[i+1] = seen[i] | req[i];
      assign grant[i]  = req[i] & ~seen[i];
    end
  endgenerate
endmodule

// File: rtl/mc_checkstop_ctrl.sv
module mc_checkstop_ctrl
  import mc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_tea,
  input  logic             bus_apar_err,
  input  logic             bus_dpar_err,
  input  logic             mcp_in,
  input  logic             ckstp_in,
  input  logic             snoop_lock_hit,
  input  logic [PAR_N-1:0] par_err,
  input  logic             l2_snoop_err_en,
  input  logic             l2_tag_par_en,
  input  logic             msr_me,
  input  logic             ctl_wr_en,
  input  logic [CTL_W-1:0] ctl_wr_data,
  output logic [CTL_W-1:0] ctl_rd_data,
  input  logic             mc_ack,
  output logic             mc_irq,
  output logic             core_halt,
  output logic             ckstp_out,
  output logic [NSRC-1:0]  src_latch
);
  logic [CTL_W-1:0] ctl_q;
  logic [MC_N-1:0]  qual;
  logic [MC_N-1:0]  first_mc;
  logic [NSRC-1:0]  entry_src;
  logic             any_mc, enter_ck, raise_irq;
  logic             ck_q, irq_q;
  logic [NSRC-1:0]  src_q;

  mc_ctl_reg #(.W(CTL_W), .MASK(CTL_MASK)) u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(ctl_wr_en),
    .wr_data(ctl_wr_data), .q(ctl_q)
  );

  mc_qualify u_qual (
    .bus_tea(bus_tea), .bus_apar_err(bus_apar_err), .bus_dpar_err(bus_dpar_err),
    .mcp_in(mcp_in), .snoop_lock_hit(snoop_lock_hit), .par_err(par_err),
    .l2_snoop_err_en(l2_snoop_err_en), .l2_tag_par_en(l2_tag_par_en),
    .ctl(ctl_q), .qual(qual)
  );

  mc_first_pick #(.N(MC_N)) u_pick (.req(qual), .grant(first_mc));

  assign any_mc = |qual;

  // checkstop pin outranks any machine-check source
  always_comb begin
    entry_src = '0;
    if (ckstp_in) entry_src[S_CKIN]   = 1'b1;
    else          entry_src[MC_N-1:0] = first_mc;
  end

  assign enter_ck  = ~ck_q & (ckstp_in | (any_mc & ~msr_me));
  assign raise_irq = ~ck_q & ~ckstp_in & any_mc & msr_me;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_q  <= 1'b0;
      src_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (enter_ck) begin
        ck_q  <= 1'b1;
        src_q <= entry_src;
      end
      if (raise_irq)   irq_q <= 1'b1;
      else if (mc_ack) irq_q <= 1'b0;
    end
  end

  assign ctl_rd_data = ctl_q;
  assign mc_irq      = irq_q;
  assign core_halt   = ck_q;
  assign ckstp_out   = ck_q;
  assign src_latch   = src_q;
endmodule

// File: rtl/mc_checkstop_chk.sv
module mc_checkstop_chk
  import mc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             ckstp_in,
  input logic             msr_me,
  input logic             mc_ack,
  input logic             mc_irq,
  input logic             core_halt,
  input logic             ckstp_out,
  input logic [CTL_W-1:0] ctl_rd_data,
  input logic [NSRC-1:0]  src_latch
);
  assert_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ckstp_out |=> ckstp_out);

  assert_halt_pair_R1: assert property (@(posedge clk) disable iff (!rst_n)
    core_halt == ckstp_out);

  assert_pin_forces_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ckstp_in |=> ckstp_out);

  assert_pin_no_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ckstp_in && !mc_irq) |=> !mc_irq);

  assert_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ckstp_out |-> $onehot(src_latch));

  assert_zero_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ckstp_out |-> (src_latch == '0));

  assert_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ckstp_out |=> $stable(src_latch));

  assert_irq_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_irq && !mc_ack) |=> mc_irq);

  assert_no_new_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ckstp_out && !mc_irq) |=> !mc_irq);

  assert_unused_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rd_data & ~CTL_MASK) == '0);
endmodule

bind mc_checkstop_ctrl mc_checkstop_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ckstp_in(ckstp_in), .msr_me(msr_me),
  .mc_ack(mc_ack), .mc_irq(mc_irq), .core_halt(core_halt),
  .ckstp_out(ckstp_out), .ctl_rd_data(ctl_rd_data), .src_latch(src_latch)
);

// File: tb/mc_checkstop_ctrl_tb_top.sv
module mc_checkstop_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_tea = 0, bus_apar_err = 0, bus_dpar_err = 0, mcp_in = 0, ckstp_in = 0;
  logic snoop_lock_hit = 0, l2_snoop_err_en = 0, l2_tag_par_en = 0, msr_me = 0;
  logic [4:0] par_err = '0;
  logic ctl_wr_en = 0, mc_ack = 0;
  logic [7:0] ctl_wr_data = '0;
  logic [7:0] ctl_rd_data;
  logic mc_irq, core_halt, ckstp_out;
  logic [10:0] src_latch;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;   // 50 MHz

  mc_checkstop_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_tea(bus_tea), .bus_apar_err(bus_apar_err),
    .bus_dpar_err(bus_dpar_err), .mcp_in(mcp_in), .ckstp_in(ckstp_in),
    .snoop_lock_hit(snoop_lock_hit), .par_err(par_err),
    .l2_snoop_err_en(l2_snoop_err_en), .l2_tag_par_en(l2_tag_par_en),
    .msr_me(msr_me), .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
    .ctl_rd_data(ctl_rd_data), .mc_ack(mc_ack), .mc_irq(mc_irq),
    .core_halt(core_halt), .ckstp_out(ckstp_out), .src_latch(src_latch)
  );

  // ---------------- behavioural reference model ----------------
  logic        m_ck = 0, m_irq = 0;
  logic [10:0] m_src = '0;
  logic [7:0]  m_ctl = '0;

  always @(posedge clk) begin
    logic [9:0] q;
    if (!rst_n) begin
      m_ck = 0; m_irq = 0; m_src = '0; m_ctl = '0;
    end else begin
      q = '0;
      q[0] = bus_tea;
      q[1] = bus_apar_err && m_ctl[2];
      q[2] = bus_dpar_err && m_ctl[3];
      q[3] = mcp_in && m_ctl[0];
      q[4] = snoop_lock_hit && l2_snoop_err_en;
      q[5] = par_err[0]; q[6] = par_err[1]; q[7] = par_err[2]; q[8] = par_err[3];
      q[9] = par_err[4] && l2_tag_par_en;
      if (!m_ck && ckstp_in) begin
        m_ck = 1; m_src = 11'h400;
        if (mc_ack) m_irq = 0;
      end else if (!m_ck && q != 0 && !msr_me) begin
        m_ck = 1;
        for (int i = 9; i >= 0; i--) if (q[i]) m_src = 11'(1 << i);
        if (mc_ack) m_irq = 0;
      end else if (!m_ck && q != 0) begin
        m_irq = 1;
      end else if (mc_ack) begin
        m_irq = 0;
      end
      if (ctl_wr_en) m_ctl = ctl_wr_data & 8'h0D;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      chk("R1 ckstp_out", 32'(ckstp_out), 32'(m_ck));
      chk("R1 core_halt", 32'(core_halt), 32'(m_ck));
      chk("R9 mc_irq", 32'(mc_irq), 32'(m_irq));
      chk("R8 src_latch", 32'(src_latch), 32'(m_src));
      chk("R11 ctl_rd_data", 32'(ctl_rd_data), 32'(m_ctl));
    end
  end

  task automatic clr_ev();
    bus_tea = 0; bus_apar_err = 0; bus_dpar_err = 0; mcp_in = 0; ckstp_in = 0;
    snoop_lock_hit = 0; par_err = '0; mc_ack = 0; ctl_wr_en = 0;
  endtask

  task automatic hard_reset();
    @(negedge clk); clr_ev(); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    @(negedge clk); ctl_wr_en = 1; ctl_wr_data = v;
    @(negedge clk); ctl_wr_en = 0;
  endtask

  // one-cycle strobe; returns after result is due
  task automatic step();
    @(negedge clk); clr_ev();
  endtask

  initial begin
    #(200000 * 20);
    errors++; checks++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset src", 32'(src_latch), 0);
    chk("R11 reset ctl", 32'(ctl_rd_data), 0);
    rst_n = 1;

    // R11: unused bits
    wr_ctl(8'hFF);
    chk("R11 masked write", 32'(ctl_rd_data), 32'h0D);
    wr_ctl(8'h00);

    // R4: pin masked, then enabled with ME=1 -> irq
    msr_me = 1;
    @(negedge clk); mcp_in = 1; step();
    chk("R4 masked pin no irq", 32'(mc_irq), 0);
    chk("R4 masked pin no ckstp", 32'(ckstp_out), 0);
    wr_ctl(8'h01);
    @(negedge clk); mcp_in = 1; step();
    chk("R2 pin irq", 32'(mc_irq), 1);
    // R9: hold, merge, ack-vs-event
    @(negedge clk); bus_tea = 1; step();
    chk("R9 merged", 32'(mc_irq), 1);
    @(negedge clk); mc_ack = 1; bus_tea = 1; step();
    chk("R9 event beats ack", 32'(mc_irq), 1);
    @(negedge clk); mc_ack = 1; step();
    chk("R9 ack clears", 32'(mc_irq), 0);

    // R5: parity disabled ignored
    wr_ctl(8'h00);
    @(negedge clk); bus_apar_err = 1; bus_dpar_err = 1; step();
    chk("R5 parity off", 32'(mc_irq), 0);
    wr_ctl(8'h08);
    @(negedge clk); bus_dpar_err = 1; step();
    chk("R5 dpar on", 32'(mc_irq), 1);
    @(negedge clk); mc_ack = 1; step();

    // R6: L2 gates
    @(negedge clk); snoop_lock_hit = 1; par_err = 5'b10000; step();
    chk("R6 gated off", 32'(mc_irq), 0);
    l2_tag_par_en = 1;
    @(negedge clk); par_err = 5'b10000; step();
    chk("R6 l2tag on", 32'(mc_irq), 1);
    @(negedge clk); mc_ack = 1; step();

    // R3: ckstp_in with event, ME=1 -> checkstop, no irq
    @(negedge clk); ckstp_in = 1; bus_tea = 1; step();
    chk("R3 ckstp wins", 32'(ckstp_out), 1);
    chk("R3 no irq", 32'(mc_irq), 0);
    chk("R8 pin source", 32'(src_latch), 32'h400);
    // R10: events ignored in checkstop
    @(negedge clk); bus_tea = 1; step();
    chk("R10 no irq in ckstp", 32'(mc_irq), 0);
    chk("R8 frozen", 32'(src_latch), 32'h400);
    repeat (5) @(negedge clk);
    chk("R1 held", 32'(ckstp_out), 1);

    // R2/R7/R8: ME=0, multiple sources -> lowest index
    hard_reset();
    chk("R1 reset clears", 32'(ckstp_out), 0);
    msr_me = 0;
    @(negedge clk); par_err = 5'b01010; step();
    chk("R2 ckstp ME0", 32'(ckstp_out), 1);
    chk("R7 dtag source", 32'(src_latch), 32'h040);
    chk("R2 no irq ME0", 32'(mc_irq), 0);

    // R10: pending irq still clears in checkstop
    hard_reset();
    msr_me = 1;
    @(negedge clk); bus_tea = 1; step();
    msr_me = 0;
    @(negedge clk); par_err = 5'b00001; step();
    chk("R8 itag source", 32'(src_latch), 32'h020);
    chk("R10 irq pending", 32'(mc_irq), 1);
    @(negedge clk); mc_ack = 1; step();
    chk("R10 ack in ckstp", 32'(mc_irq), 0);

    // random phase, model compared every cycle
    for (int r = 0; r < 40; r++) begin
      hard_reset();
      l2_snoop_err_en = 1'($urandom);
      l2_tag_par_en   = 1'($urandom);
      for (int c = 0; c < 60; c++) begin
        @(negedge clk);
        clr_ev();
        msr_me         = ($urandom % 4) != 0;
        bus_tea        = ($urandom % 20) == 0;
        bus_apar_err   = ($urandom % 10) == 0;
        bus_dpar_err   = ($urandom % 10) == 0;
        mcp_in         = ($urandom % 10) == 0;
        snoop_lock_hit = ($urandom % 12) == 0;
        par_err        = (($urandom % 8) == 0) ? 5'($urandom) : 5'd0;
        ckstp_in       = ($urandom % 80) == 0;
        mc_ack         = ($urandom % 4) == 0;
        ctl_wr_en      = ($urandom % 15) == 0;
        ctl_wr_data    = 8'($urandom);
      end
    end
    @(negedge clk); clr_ev();
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule